// File: doc/BRIEF.md
# Prescaled Timer with Compare Output

An 8-bit up-counter whose advance is gated by a selectable count enable. A 3-bit select code picks the enable from a free-running system-clock prescaler or from one edge of an external count pin. The counter can be stopped, and software can load it with any value at any time. A common use is to reload a start value after every wrap, which gives a fixed period.

Two sticky event flags report a wrap from all-ones to zero and a compare match. Each flag clears on a write-one strobe or on an interrupt acknowledge. On every compare match, the compare output pin can be toggled, cleared or set by hardware, with no software step involved.

Everything runs on the system clock. The prescaler divisions are one-cycle enable pulses, not derived clocks. The external pin passes through a synchronizer before its edges are detected.

Top module: `prescaled_timer`

## Requirements
- R1: While `rstN` is low and after its release, `count` is 0, `ovfFlag` and `cmpFlag` are 0, and `cmpOut` is 0.
- R2: `clkSel` selects how the counter advances by one:
  - 000: the counter never advances.
  - 001: the counter advances on every clock edge.
  - 010, 011, 100, 101: the counter advances only on clock edges whose number since reset release is a multiple of 8, 64, 256 or 1024 respectively, counting the first edge after release as edge 1.
- R3: With `clkSel` 111, each 0-to-1 change of `extPin` advances the counter by exactly one. With `clkSel` 110, each 1-to-0 change does so. In both cases the advance lands on the third rising clock edge after the pin changes.
- R4: When the counter advances from 8'hFF to 8'h00, `ovfFlag` becomes 1 on that same edge.
- R5: When the counter advances while `count` equals `cmpVal`, `cmpFlag` becomes 1 on that same edge.
- R6: On each compare match, `outMode` acts on `cmpOut` as follows: 00 leaves it unchanged, 01 inverts it, 10 drives it to 0, 11 drives it to 1. `cmpOut` changes at no other time.
- R7: A flag is cleared on the next edge by its write-one strobe (`ovfClr`, `cmpClr`) or by its acknowledge (`ovfAck`, `cmpAck`). If the flag's event occurs in the same cycle as the clear, the flag stays 1.
- R8: When `cntWrEn` is high, `count` takes `cntWrData` on the next edge instead of advancing. In that cycle neither a wrap nor a compare match is recognised.
- R9: A flag that is set stays set, whatever the counter does, until it is cleared as in R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| extPin | input | 1 | External count pin, asynchronous |
| clkSel | input | 3 | Count source select |
| cmpVal | input | 8 | Compare value |
| outMode | input | 2 | Compare output action |
| cntWrEn | input | 1 | Counter load strobe |
| cntWrData | input | 8 | Counter load value |
| ovfClr | input | 1 | Write-one clear of the overflow flag |
| cmpClr | input | 1 | Write-one clear of the compare flag |
| ovfAck | input | 1 | Overflow interrupt acknowledge |
| cmpAck | input | 1 | Compare interrupt acknowledge |
| count | output | 8 | Current count |
| ovfFlag | output | 1 | Overflow flag |
| cmpFlag | output | 1 | Compare match flag |
| cmpOut | output | 1 | Compare output pin |

## Verification
The count, both flags and the compare pin respond to a stimulus on the first rising edge after the cycle in which that stimulus is present. The one exception is the external pin, whose change reaches the count on the third rising edge. The bench drives inputs on the falling edge and advances its own model by one edge. It then queues the predicted outputs, and a monitor compares them 1 ns after the following rising edge. Any extra or missing register stage on any path therefore shows up as a mismatch in that exact cycle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef struct packed {
    logic tick;   // counter may advance this cycle
    logic load;   // software load overrides advance and events
  } tmrStrobe_t;

  typedef enum logic [2:0] {
    CS_STOP     = 3'b000,
    CS_DIV1     = 3'b001,
    CS_DIV8     = 3'b010,
    CS_DIV64    = 3'b011,
    CS_DIV256   = 3'b100,
    CS_DIV1024  = 3'b101,
    CS_EXT_FALL = 3'b110,
    CS_EXT_RISE = 3'b111
  } clkSel_e;

  typedef enum logic [1:0] {
    OM_NONE   = 2'b00,
    OM_TOGGLE = 2'b01,
    OM_CLEAR  = 2'b10,
    OM_SET    = 2'b11
  } outMode_e;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int PRESC_BITS = 10,
  parameter int NUM_TAPS   = 4
) (
  input  logic                clk,
  input  logic                rstN,
  output logic [NUM_TAPS-1:0] tapHit
);
  // log2 of each division ratio: 8, 64, 256, 1024
  function automatic int tapLog(input int idx);
    case (idx)
      0:       return 3;
      1:       return 6;
      2:       return 8;
      default: return 10;
    endcase
  endfunction

  logic [PRESC_BITS-1:0] presc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) presc <= '0;
    else       presc <= presc + 1'b1;
  end

  for (genvar g = 0; g < NUM_TAPS; g++) begin : gTap
    localparam int LW = tapLog(g);
    assign tapHit[g] = &presc[LW-1:0];
  end
endmodule

// File: rtl/tmr_extsync.sv
module tmr_extsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic pinIn,
  output logic pinRise,
  output logic pinFall
);
  logic [STAGES:0] syn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syn <= '0;
    else       syn <= {syn[STAGES-1:0], pinIn};
  end

  assign pinRise =  syn[STAGES-1] & ~syn[STAGES];
  assign pinFall = ~syn[STAGES-1] &  syn[STAGES];
endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int PRESC_BITS  = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       extPin,
  input  logic [2:0] clkSel,
  input  logic       cntWrEn,
  output tmrStrobe_t strobe
);
  localparam int NUM_TAPS = 4;

  logic [NUM_TAPS-1:0] tapHit;
  logic pinRise, pinFall;
  logic tick;

  tmr_prescale #(.PRESC_BITS(PRESC_BITS), .NUM_TAPS(NUM_TAPS)) uPresc (
    .clk(clk), .rstN(rstN), .tapHit(tapHit)
  );

  tmr_extsync #(.STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN), .pinIn(extPin),
    .pinRise(pinRise), .pinFall(pinFall)
  );

  always_comb begin
    case (clkSel_e'(clkSel))
      CS_STOP:     tick = 1'b0;
      CS_DIV1:     tick = 1'b1;
      CS_DIV8:     tick = tapHit[0];
      CS_DIV64:    tick = tapHit[1];
      CS_DIV256:   tick = tapHit[2];
      CS_DIV1024:  tick = tapHit[3];
      CS_EXT_FALL: tick = pinFall;
      default:     tick = pinRise;
    endcase
  end

  assign strobe.tick = tick;
  assign strobe.load = cntWrEn;
endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmrStrobe_t       strobe,
  input  logic [WIDTH-1:0] cntWrData,
  input  logic [WIDTH-1:0] cmpVal,
  input  logic [1:0]       outMode,
  input  logic             ovfClr,
  input  logic             cmpClr,
  input  logic             ovfAck,
  input  logic             cmpAck,
  output logic [WIDTH-1:0] count,
  output logic             ovfFlag,
  output logic             cmpFlag,
  output logic             cmpOut
);
  localparam logic [WIDTH-1:0] TOP = '1;

  logic advance, ovfEvt, matchEvt;

  assign advance  = strobe.tick & ~strobe.load;
  assign ovfEvt   = advance & (count == TOP);
  assign matchEvt = advance & (count == cmpVal);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            count <= '0;
    else if (strobe.load) count <= cntWrData;
    else if (advance)     count <= count + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ovfFlag <= 1'b0;
      cmpFlag <= 1'b0;
    end else begin
      ovfFlag <= ovfEvt   | (ovfFlag & ~(ovfClr | ovfAck));
      cmpFlag <= matchEvt | (cmpFlag & ~(cmpClr | cmpAck));
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cmpOut <= 1'b0;
    else if (matchEvt) begin
      case (outMode_e'(outMode))
        OM_TOGGLE: cmpOut <= ~cmpOut;
        OM_CLEAR:  cmpOut <= 1'b0;
        OM_SET:    cmpOut <= 1'b1;
        default:   cmpOut <= cmpOut;
      endcase
    end
  end
endmodule

// File: rtl/prescaled_timer.sv
module prescaled_timer
  import tmr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       extPin,
  input  logic [2:0] clkSel,
  input  logic [7:0] cmpVal,
  input  logic [1:0] outMode,
  input  logic       cntWrEn,
  input  logic [7:0] cntWrData,
  input  logic       ovfClr,
  input  logic       cmpClr,
  input  logic       ovfAck,
  input  logic       cmpAck,
  output logic [7:0] count,
  output logic       ovfFlag,
  output logic       cmpFlag,
  output logic       cmpOut
);
  tmrStrobe_t strobe;

  tmr_ctrl #(.PRESC_BITS(10), .SYNC_STAGES(2)) uCtrl (
    .clk(clk), .rstN(rstN), .extPin(extPin), .clkSel(clkSel),
    .cntWrEn(cntWrEn), .strobe(strobe)
  );

  tmr_datapath #(.WIDTH(8)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cntWrData(cntWrData),
    .cmpVal(cmpVal), .outMode(outMode), .ovfClr(ovfClr), .cmpClr(cmpClr),
    .ovfAck(ovfAck), .cmpAck(cmpAck), .count(count), .ovfFlag(ovfFlag),
    .cmpFlag(cmpFlag), .cmpOut(cmpOut)
  );
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker (
  input logic       clk,
  input logic       rstN,
  input logic [2:0] clkSel,
  input logic [7:0] cmpVal,
  input logic [1:0] outMode,
  input logic       cntWrEn,
  input logic [7:0] cntWrData,
  input logic [7:0] count,
  input logic       ovfFlag,
  input logic       cmpFlag,
  input logic       cmpOut
);
  assert_stop_holds_R2: assert property (@(posedge clk) disable iff (!rstN)
    (clkSel == 3'b000 && !cntWrEn) |=> $stable(count));

  assert_step_by_one_R2: assert property (@(posedge clk) disable iff (!rstN)
    (count != $past(count) && !$past(cntWrEn)) |-> (count == $past(count) + 8'd1));

  assert_wrap_sets_flag_R4: assert property (@(posedge clk) disable iff (!rstN)
    (count == 8'h00 && $past(count) == 8'hFF && !$past(cntWrEn)) |-> ovfFlag);

  assert_match_origin_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cmpFlag) |-> ($past(count) == $past(cmpVal) && !$past(cntWrEn)));

  assert_pin_only_on_match_R6: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(cmpOut) |-> ($past(count) == $past(cmpVal) && $past(outMode) != 2'b00));

  assert_load_value_R8: assert property (@(posedge clk) disable iff (!rstN)
    cntWrEn |=> (count == $past(cntWrData)));
endmodule

bind prescaled_timer tmr_checker uChk (.*);

// File: tb/sim_prescaled_timer.sv
module sim_prescaled_timer;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic extPin = 1'b0;
  logic [2:0] clkSel = '0;
  logic [7:0] cmpVal = '0;
  logic [1:0] outMode = '0;
  logic cntWrEn = 1'b0;
  logic [7:0] cntWrData = '0;
  logic ovfClr = 1'b0, cmpClr = 1'b0, ovfAck = 1'b0, cmpAck = 1'b0;
  logic [7:0] count;
  logic ovfFlag, cmpFlag, cmpOut;

  always #2 clk = ~clk;

  prescaled_timer u0 (.*);

  typedef struct {
    logic [7:0] cnt;
    logic ovf;
    logic cmp;
    logic out;
    string tag;
  } expItem_t;

  expItem_t expQ[$];
  int nCompared = 0;
  int nMismatched = 0;

  // model state
  int unsigned mEdge;
  logic [7:0] mCnt;
  logic mOvf, mCmp, mOut, mS1, mS2, mS3;

  task automatic modelReset();
    mEdge = 0; mCnt = '0; mOvf = 0; mCmp = 0; mOut = 0;
    mS1 = 0; mS2 = 0; mS3 = 0;
  endtask

  // predicts the outputs after the coming rising edge, then passes it
  task automatic step(input string tag);
    logic tk, evO, evM, rise, fall;
    expItem_t it;
    rise = mS2 & ~mS3;
    fall = ~mS2 & mS3;
    mEdge++;
    case (clkSel)
      3'd0: tk = 0;
      3'd1: tk = 1;
      3'd2: tk = (mEdge % 8) == 0;
      3'd3: tk = (mEdge % 64) == 0;
      3'd4: tk = (mEdge % 256) == 0;
      3'd5: tk = (mEdge % 1024) == 0;
      3'd6: tk = fall;
      default: tk = rise;
    endcase
    evO = tk && !cntWrEn && mCnt == 8'hFF;
    evM = tk && !cntWrEn && mCnt == cmpVal;
    if (cntWrEn) mCnt = cntWrData;
    else if (tk) mCnt = mCnt + 8'd1;
    mOvf = evO | (mOvf & !(ovfClr | ovfAck));
    mCmp = evM | (mCmp & !(cmpClr | cmpAck));
    if (evM) begin
      case (outMode)
        2'd1: mOut = ~mOut;
        2'd2: mOut = 0;
        2'd3: mOut = 1;
        default: ;
      endcase
    end
    mS3 = mS2; mS2 = mS1; mS1 = extPin;
    it.cnt = mCnt; it.ovf = mOvf; it.cmp = mCmp; it.out = mOut; it.tag = tag;
    expQ.push_back(it);
    @(negedge clk);
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  task automatic loadCnt(input logic [7:0] v, input string tag);
    cntWrEn = 1; cntWrData = v;
    step(tag);
    cntWrEn = 0;
  endtask

  task automatic clearFlags();
    ovfClr = 1; cmpClr = 1;
    step("R7");
    ovfClr = 0; cmpClr = 0;
  endtask

  // monitor
  always @(posedge clk) begin
    #1;
    if (expQ.size() > 0) begin
      expItem_t e;
      e = expQ.pop_front();
      nCompared++;
      if (count !== e.cnt || ovfFlag !== e.ovf || cmpFlag !== e.cmp || cmpOut !== e.out) begin
        nMismatched++;
        $display("FAIL %s: actual cnt=%02h ovf=%0b cmp=%0b out=%0b expected cnt=%02h ovf=%0b cmp=%0b out=%0b",
                 e.tag, count, ovfFlag, cmpFlag, cmpOut, e.cnt, e.ovf, e.cmp, e.out);
      end
    end
  end

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatched);
    $finish;
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    nCompared++;
    nMismatched++;
    $display("FAIL watchdog: actual still running, expected finished");
    finishRun();
  end

  initial begin
    // R1: reset values
    clkSel = 3'd1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    nCompared++;
    if (count !== 8'h00 || ovfFlag !== 0 || cmpFlag !== 0 || cmpOut !== 0) begin
      nMismatched++;
      $display("FAIL R1: actual cnt=%02h ovf=%0b cmp=%0b out=%0b expected 00 0 0 0",
               count, ovfFlag, cmpFlag, cmpOut);
    end
    clkSel = 3'd0;
    rstN = 1'b1;
    modelReset();
    run(3, "R1");

    // R2: every clock, stopped, prescale taps
    clkSel = 3'd1; run(20, "R2");
    clkSel = 3'd0; run(10, "R2");
    clkSel = 3'd2; run(40, "R2");
    clkSel = 3'd3; run(200, "R2");
    clkSel = 3'd4; run(600, "R2");
    clkSel = 3'd5; run(2100, "R2");

    // R4, R5, R6 toggle across wraps
    clkSel = 3'd1; cmpVal = 8'h05; outMode = 2'd1;
    loadCnt(8'hFD, "R8");
    run(300, "R5");

    // R7: each clear path
    ovfClr = 1; step("R7"); ovfClr = 0;
    clkSel = 3'd0;
    cmpAck = 1; step("R7"); cmpAck = 0;
    clkSel = 3'd1;
    run(260, "R4");
    ovfAck = 1; step("R7"); ovfAck = 0;
    cmpClr = 1; step("R7"); cmpClr = 0;
    run(5, "R7");

    // R7: event wins over simultaneous clear
    clearFlags();
    loadCnt(8'hFF, "R8");
    ovfClr = 1; ovfAck = 1; step("R7"); ovfClr = 0; ovfAck = 0;
    loadCnt(8'h05, "R8");
    cmpClr = 1; cmpAck = 1; step("R7"); cmpClr = 0; cmpAck = 0;

    // R9: sticky with clock stopped
    clkSel = 3'd0; run(20, "R9");

    // R8: load blocks match and wrap
    clkSel = 3'd1; clearFlags();
    cmpVal = 8'h40;
    loadCnt(8'h40, "R8");
    loadCnt(8'h41, "R8");
    loadCnt(8'hFF, "R8");
    loadCnt(8'h10, "R8");
    run(5, "R8");

    // R6: clear, set, none
    cmpVal = 8'h80;
    outMode = 2'd2; run(300, "R6");
    outMode = 2'd3; run(300, "R6");
    outMode = 2'd0; run(300, "R6");
    outMode = 2'd2; run(300, "R6");

    // R3: external edges, rising then falling
    clkSel = 3'd7;
    for (int k = 0; k < 40; k++) begin
      extPin = ~extPin; run(4, "R3");
    end
    clkSel = 3'd6;
    for (int k = 0; k < 40; k++) begin
      extPin = ~extPin; run(3 + (k % 3), "R3");
    end
    clkSel = 3'd0; run(5, "R3");

    @(posedge clk); #2;
    finishRun();
  end
endmodule